// File: doc/BRIEF.md
# Programmable Pin Command Sequencer

This block turns a stream of short command words into timed activity on a small group of IO pins. Each word names an operation, a pin and an argument. The sequencer can drive the selected pin high or low, pause for a number of steps, or release the pin and sample its level. Each sampled level goes out as a result word. Words enter through a valid/ready stream into a command queue. Results leave through a second queue as a valid/ready stream.

The rate at which commands are taken is set by a programmable step divider. A programmable settle delay places the sampling point of a read a chosen number of clock cycles after the read is taken. Pin inputs pass through a parameterised chain of synchronizing registers before they are sampled. The divider value and the settle delay are plain control inputs, and software or a front end may hold them steady.

Back-pressure rules: a command word is transferred on a rising clock edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` falls while the command queue is full. A result word is transferred on an edge where both `res_valid` and `res_ready` are high. While `res_ready` is low, `res_valid` and `res_data` hold. When the result queue is full, the read being executed stalls and keeps its sample, and no later command is taken until that sample has been queued.

Top module: `pin_cmd_seq`

## Requirements
- R1: Opcode 0 sets `pin_out` of the selected pin to 1 and opcode 1 sets it to 0. Both set that pin's `pin_oe` to 1 and leave every other pin unchanged.
- R2: A command word is laid out as {argument[DATA_W-1:0], pin index[IDX_W-1:0], opcode[1:0]}, with the opcode in bits 1:0 and the pin index just above it. For the default of 4 pins, the index sits in bits 3:2. The argument does not affect opcodes 0 and 1.
- R3: Opcode 2 is a pause of n steps, where n is the argument. The pins do not change during the pause. The next command is taken max(n,1) steps after the pause was taken, so n = 0 and n = 1 both last a single step.
- R4: One step occurs every `div_value`+1 clock cycles, so a `div_value` of 0 gives one step per cycle. Pin outputs and output enables change only on steps, and consecutive commands are taken on consecutive steps.
- R5: Opcode 3 clears `pin_oe` of the selected pin. It samples the synchronized level of that pin `rd_delay`+1 clock cycles after the command is taken, and emits the result word {pin index, sampled bit} with the sampled bit in bit 0. A later opcode 0 or 1 sets the enable again.
- R6: Pin inputs pass through SYNC_DEPTH registers before sampling. A level change seen for the first time one cycle before the sampling point is not captured with the default depth of 2, but it is captured one cycle later.
- R7: When the result queue is full, a read stalls without losing its sample. All results leave in command order, and `res_data` holds while `res_valid` is high and `res_ready` is low.
- R8: While the command queue is empty, every pin keeps its last `pin_out` and `pin_oe`.
- R9: After reset, `pin_out` and `pin_oe` are all 0, `res_valid` is 0 and `cmd_ready` is 1.
- R10: The command queue accepts exactly CMD_DEPTH words while the engine is busy, and then it drops `cmd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command queue has room |
| cmd_data | input | CMD_W | Command word {argument, pin index, opcode} |
| res_valid | output | 1 | Result word available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | IDX_W+1 | Result {pin index, sampled bit} |
| div_value | input | DIV_W | Step divider; 0 means a step every cycle |
| rd_delay | input | RDLY_W | Cycles between read acceptance and sampling, minus one |
| pin_in | input | PINS | Pin levels from the pads |
| pin_out | output | PINS | Driven pin levels |
| pin_oe | output | PINS | Pin output enables |

## Verification
Timing is measured as the cycle distance between a pin's rise and its fall. Pause arguments of 0, 1, 3 and 7 tell a correct max(n,1) count apart from off-by-one counting and from a missing zero case. Divider values of 0, 1 and 3 tell apart each step period. For reads, the pin level is flipped at a known cycle after the enable falls. This separates a correct settle delay from an ignored one, and a two-stage synchronizer from a shorter chain. Ten reads against a stalled result queue, over pins with mixed levels, expose lost, duplicated or reordered samples.

// File: rtl/pin_seq_pkg.sv
package pin_seq_pkg;

  typedef enum logic [1:0] {
    OP_DRIVE_HI = 2'd0,
    OP_DRIVE_LO = 2'd1,
    OP_PAUSE    = 2'd2,
    OP_SAMPLE   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_PAUSE,
    ST_SETTLE,
    ST_EMIT
  } st_e;

endpackage

// File: rtl/pin_seq_fifo.sv
module pin_seq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push, pop;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pin_seq_sync.sv
module pin_seq_sync #(
  parameter int W     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] stage [DEPTH];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else begin
          stage[0] <= d;
          for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
      end
      assign q = stage[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/pin_seq_divider.sv
module pin_seq_divider #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt;

  // >= lets a lowered limit take effect without a counter wrap
  assign tick = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pin_seq_engine.sv
module pin_seq_engine
  import pin_seq_pkg::*;
#(
  parameter int PINS   = 4,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 24,
  parameter int RDLY_W = 8,
  parameter int CMD_W  = 2 + IDX_W + DATA_W,
  parameter int RES_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [RDLY_W-1:0] rd_delay,
  input  logic [PINS-1:0]   pin_sync,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [RES_W-1:0]  res_word,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);
  op_e               op;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] arg;
  st_e               state;
  logic [DATA_W-1:0] pause_left;
  logic [RDLY_W-1:0] settle_left;
  logic [IDX_W-1:0]  cur_idx;
  logic              sample;
  logic              sel_bit;
  logic              take;

  assign op  = op_e'(cmd_word[1:0]);
  assign idx = cmd_word[IDX_W+1:2];
  assign arg = cmd_word[CMD_W-1:IDX_W+2];

  assign cmd_ready = (state == ST_FETCH) && tick;
  assign take      = cmd_ready && cmd_valid;
  assign res_valid = (state == ST_EMIT);
  assign res_word  = {cur_idx, sample};

  // pin select by loop so an index beyond PINS reads as 0
  always_comb begin
    sel_bit = 1'b0;
    for (int p = 0; p < PINS; p++) begin
      if (cur_idx == IDX_W'(p)) sel_bit = pin_sync[p];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_FETCH;
      pin_out     <= '0;
      pin_oe      <= '0;
      pause_left  <= '0;
      settle_left <= '0;
      cur_idx     <= '0;
      sample      <= 1'b0;
    end else begin
      case (state)
        ST_FETCH: begin
          if (take) begin
            case (op)
              OP_DRIVE_HI, OP_DRIVE_LO: begin
                for (int p = 0; p < PINS; p++) begin
                  if (idx == IDX_W'(p)) begin
                    pin_out[p] <= (op == OP_DRIVE_HI);
                    pin_oe[p]  <= 1'b1;
                  end
                end
              end
              OP_PAUSE: begin
                if (arg > DATA_W'(1)) begin
                  pause_left <= arg - 1'b1;
                  state      <= ST_PAUSE;
                end
              end
              default: begin
                for (int p = 0; p < PINS; p++) begin
                  if (idx == IDX_W'(p)) pin_oe[p] <= 1'b0;
                end
                cur_idx     <= idx;
                settle_left <= rd_delay;
                state       <= ST_SETTLE;
              end
            endcase
          end
        end
        ST_PAUSE: begin
          if (tick) begin
            if (pause_left == DATA_W'(1)) state <= ST_FETCH;
            else                          pause_left <= pause_left - 1'b1;
          end
        end
        ST_SETTLE: begin
          if (settle_left == '0) begin
            sample <= sel_bit;
            state  <= ST_EMIT;
          end else begin
            settle_left <= settle_left - 1'b1;
          end
        end
        default: begin
          if (res_ready) state <= ST_FETCH;
        end
      endcase
    end
  end
endmodule

// File: rtl/pin_cmd_seq.sv
module pin_cmd_seq #(
  parameter int PINS       = 4,
  parameter int DATA_W     = 24,
  parameter int DIV_W      = 20,
  parameter int RDLY_W     = 8,
  parameter int SYNC_DEPTH = 2,
  parameter int CMD_DEPTH  = 16,
  parameter int RES_DEPTH  = 8,
  localparam int IDX_W     = (PINS > 1) ? $clog2(PINS) : 1,
  localparam int CMD_W     = 2 + IDX_W + DATA_W,
  localparam int RES_W     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [RES_W-1:0]  res_data,
  input  logic [DIV_W-1:0]  div_value,
  input  logic [RDLY_W-1:0] rd_delay,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);
  logic             q_cmd_valid, q_cmd_ready;
  logic [CMD_W-1:0] q_cmd_word;
  logic             e_res_valid, e_res_ready;
  logic [RES_W-1:0] e_res_word;
  logic [PINS-1:0]  pin_sync;
  logic             tick;

  pin_seq_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) i_cmd_q (
    .clk(clk), .rst_n(rst_n),
    .in_valid(cmd_valid), .in_ready(cmd_ready), .in_data(cmd_data),
    .out_valid(q_cmd_valid), .out_ready(q_cmd_ready), .out_data(q_cmd_word)
  );

  pin_seq_fifo #(.W(RES_W), .DEPTH(RES_DEPTH)) i_res_q (
    .clk(clk), .rst_n(rst_n),
    .in_valid(e_res_valid), .in_ready(e_res_ready), .in_data(e_res_word),
    .out_valid(res_valid), .out_ready(res_ready), .out_data(res_data)
  );

  pin_seq_sync #(.W(PINS), .DEPTH(SYNC_DEPTH)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  pin_seq_divider #(.W(DIV_W)) i_div (
    .clk(clk), .rst_n(rst_n), .limit(div_value), .tick(tick)
  );

  pin_seq_engine #(
    .PINS(PINS), .IDX_W(IDX_W), .DATA_W(DATA_W), .RDLY_W(RDLY_W),
    .CMD_W(CMD_W), .RES_W(RES_W)
  ) i_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cmd_valid(q_cmd_valid), .cmd_ready(q_cmd_ready), .cmd_word(q_cmd_word),
    .rd_delay(rd_delay), .pin_sync(pin_sync),
    .res_valid(e_res_valid), .res_ready(e_res_ready), .res_word(e_res_word),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );
endmodule

// File: rtl/pin_cmd_seq_checker.sv
module pin_cmd_seq_checker #(
  parameter int PINS  = 4,
  parameter int RES_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_valid,
  input logic             res_ready,
  input logic [RES_W-1:0] res_data,
  input logic [PINS-1:0]  pin_out,
  input logic [PINS-1:0]  pin_oe,
  input logic             tick,
  input logic             q_cmd_valid,
  input logic             e_res_valid,
  input logic             e_res_ready,
  input logic [RES_W-1:0] e_res_word
);
  assert_res_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));

  assert_stall_keeps_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
    e_res_valid && !e_res_ready |=> e_res_valid && $stable(e_res_word));

  assert_step_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pin_out) && $stable(pin_oe));

  assert_one_pin_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pin_out ^ $past(pin_out)) <= 1);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !q_cmd_valid |=> $stable(pin_out) && $stable(pin_oe));
endmodule

bind pin_cmd_seq pin_cmd_seq_checker #(.PINS(PINS), .RES_W(RES_W)) i_chk (
  .clk(clk), .rst_n(rst_n),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
  .pin_out(pin_out), .pin_oe(pin_oe), .tick(tick),
  .q_cmd_valid(q_cmd_valid),
  .e_res_valid(e_res_valid), .e_res_ready(e_res_ready), .e_res_word(e_res_word)
);

// File: tb/test_pin_cmd_seq.sv
module test_pin_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PINS = 4;
  localparam int CMD_W = 28;
  localparam int RES_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [CMD_W-1:0] cmd_data = '0;
  logic res_valid;
  logic res_ready = 1'b0;
  logic [RES_W-1:0] res_data;
  logic [19:0] div_value = '0;
  logic [7:0] rd_delay = '0;
  logic [PINS-1:0] pin_in = '0;
  logic [PINS-1:0] pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t_rise = 0;
  int t_fall = 0;
  logic prev1 = 1'b0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (pin_out[1] && !prev1) t_rise = cyc;
    if (!pin_out[1] && prev1) t_fall = cyc;
    prev1 = pin_out[1];
  end

  pin_cmd_seq i_pin_cmd_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .div_value(div_value), .rd_delay(rd_delay),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [CMD_W-1:0] mk(input int op, input int idx, input int arg);
    return {arg[23:0], idx[1:0], op[1:0]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int op, input int idx, input int arg);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = mk(op, idx, arg);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic push_end();
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pop(output logic [RES_W-1:0] w);
    @(negedge clk);
    while (!res_valid) @(negedge clk);
    w = res_data;
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(pin_out == 4'b0000, "R9 pin_out", pin_out, 0);
    check(pin_oe == 4'b0000, "R9 pin_oe", pin_oe, 0);
    check(res_valid == 1'b0, "R9 res_valid", res_valid, 0);
    check(cmd_ready == 1'b1, "R9 cmd_ready", cmd_ready, 1);
  endtask

  task automatic t_drive();
    push(0, 2, 0); push_end(); settle(4);
    check(pin_out == 4'b0100, "R1 high p2 out", pin_out, 4);
    check(pin_oe == 4'b0100, "R1 high p2 oe", pin_oe, 4);
    push(0, 0, 0); push(1, 2, 0); push_end(); settle(4);
    check(pin_out == 4'b0001, "R1 low p2 out", pin_out, 1);
    check(pin_oe == 4'b0101, "R1 low p2 oe", pin_oe, 5);
    push(1, 3, 24'h00ABCD); push_end(); settle(4);
    check(pin_oe == 4'b1101, "R1 low p3 oe", pin_oe, 13);
    // R2: index in bits 3:2, argument ignored by drive opcodes
    push(0, 3, 24'hFFFFFF); push_end(); settle(4);
    check(pin_out == 4'b1001, "R2 index field", pin_out, 9);
  endtask

  task automatic pause_gap(input int n, input int exp_gap);
    push(0, 1, 0); push(2, 0, n); push(1, 1, 0); push_end();
    settle(n + 12);
    check(t_fall - t_rise == exp_gap, "R3 pause gap", t_fall - t_rise, exp_gap);
  endtask

  task automatic t_pause();
    pause_gap(7, 8);
    pause_gap(0, 2);
    pause_gap(1, 2);
    pause_gap(3, 4);
  endtask

  task automatic div_gap(input int d, input int exp_gap);
    div_value = 20'(d);
    push(0, 1, 0); push(1, 1, 0); push_end();
    settle(4 * (d + 1) + 8);
    check(t_fall - t_rise == exp_gap, "R4 step period", t_fall - t_rise, exp_gap);
  endtask

  task automatic t_div();
    div_gap(3, 4);
    div_gap(1, 2);
    div_gap(0, 1);
  endtask

  // flip pin1 'lag' negedges after its enable falls, expect captured bit
  task automatic read_case(input int dly, input int lag, input logic exp_bit, input string req);
    logic [RES_W-1:0] w;
    pin_in = '0;
    rd_delay = 8'(dly);
    push(0, 1, 0); push(3, 1, 0); push_end();
    while (pin_oe[1]) @(negedge clk);
    check(pin_oe[1] == 1'b0, "R5 oe released", pin_oe[1], 0);
    repeat (lag) @(negedge clk);
    pin_in[1] = 1'b1;
    pop(w);
    check(w == {2'd1, exp_bit}, req, w, {2'd1, exp_bit});
    push(0, 1, 0); push_end(); settle(3);
    check(pin_oe[1] == 1'b1, "R5 oe restored", pin_oe[1], 1);
    pin_in = '0;
  endtask

  task automatic t_read();
    read_case(0, 3, 1'b0, "R5 no delay old level");
    read_case(20, 3, 1'b1, "R5 delay sees new level");
    read_case(1, 0, 1'b0, "R6 sync hides late change");
    read_case(2, 0, 1'b1, "R6 sync passes one cycle later");
    rd_delay = '0;
  endtask

  task automatic t_stall();
    logic [RES_W-1:0] w;
    pin_in = 4'b1010;
    settle(4);
    for (int k = 0; k < 10; k++) push(3, k % 4, 0);
    push_end();
    settle(60);
    check(res_valid == 1'b1, "R7 results held", res_valid, 1);
    for (int k = 0; k < 10; k++) begin
      pop(w);
      check(w == {2'(k % 4), pin_in[k % 4]}, "R7 order and value", w, {2'(k % 4), pin_in[k % 4]});
    end
    settle(10);
    check(res_valid == 1'b0, "R7 no extra result", res_valid, 0);
    pin_in = '0;
  endtask

  task automatic t_fill();
    int n = 0;
    push(2, 0, 2000); push_end(); settle(5);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (!cmd_ready) break;
      cmd_valid = 1'b1;
      cmd_data = mk(1, 0, 0);
      @(posedge clk);
      n++;
    end
    cmd_valid = 1'b0;
    check(n == 16, "R10 queue depth", n, 16);
    settle(2100);
    check(cmd_ready == 1'b1, "R10 ready after drain", cmd_ready, 1);
    push(0, 0, 0); push_end(); settle(4);
    check(pin_out[0] == 1'b1, "R10 drained queue runs", pin_out[0], 1);
  endtask

  task automatic t_idle();
    logic [PINS-1:0] o, e;
    div_value = 20'd5;
    settle(10);
    o = pin_out; e = pin_oe;
    settle(200);
    check(pin_out == o, "R8 out held", pin_out, o);
    check(pin_oe == e, "R8 oe held", pin_oe, e);
    div_value = '0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_drive();
    t_pause();
    t_div();
    t_read();
    t_stall();
    t_fill();
    t_idle();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule